// File: doc/BRIEF.md
# Moore 110 Sequence Detector

This block watches a single serial input bit, sampled on every rising clock edge, and raises its output for one clock period after the three most recent samples were 1, then 1, then 0. It is a Moore machine, so the output is decoded from the stored state alone and changes only just after a clock edge, never straight from the input.

The state is two bits with a chosen encoding. One bit is a plain copy of the previous input sample and sits in a small datapath. The other bit, which records that a run of ones has been seen or that the pattern has just finished, is produced by a short next-state equation in the control. The output decode also sits in the control. An active-low asynchronous reset clears both bits, which is the "no ones seen" state, and the detector then forgets any history collected before it.

Top module: `seq110_detector`

## Requirements
- R1: While rstN is low, yOut is 0 at once, without waiting for a clock edge, and both state bits are cleared.
- R2: yOut is 1 in the clock period after the rising edges that sampled aIn as 1, 1, 0 in that order.
- R3: yOut is 0 after every other three-sample history, including 0,1,0, 1,0,0 and 0,1,1.
- R4: yOut does not change when aIn changes between clock edges; it follows only the samples taken at rising edges.
- R5: A run of more than two ones followed by a 0 (e.g. 1,1,1,1,0) still produces yOut = 1 after the 0.
- R6: After a detection, the samples 1,1,0 produce a new detection without returning through reset; a 1 sampled in the detection period counts as the first one of the next pattern.
- R7: yOut is never 1 in two consecutive clock periods.
- R8: Samples taken before a reset do not count towards a pattern after reset is released: 1,1, reset, 0 leaves yOut at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; aIn is sampled on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| aIn | input | 1 | Serial input bit |
| yOut | output | 1 | High for one period after 1,1,0 was sampled |

## Verification
The two functions that meet in one cycle are the output of a finished detection and the capture of the first sample of the next pattern: in the period where yOut is high, aIn is already being sampled as a 1 that must start a fresh match. The bench provokes this with back-to-back patterns such as 1,1,0,1,1,0 and with an input change placed in the middle of the detection period. A scoreboard model built from the last three samples predicts yOut after every edge, so a detection that is missed, stretched or shifted by one period shows as a miscompare.

// File: rtl/seq110_pkg.sv
package seq110_pkg;

  // Encoding {patBit, lastBit}; lastBit is the previous input sample.
  typedef enum logic [1:0] {
    ST_NONE = 2'b00,  // no 1 seen (also the reset state)
    ST_ONE  = 2'b01,  // one 1 seen
    ST_RUN  = 2'b11,  // two or more consecutive 1s
    ST_HIT  = 2'b10   // 1,1,0 completed
  } detState_t;

  // What the datapath shows the control each cycle.
  typedef struct packed {
    logic lastBit;  // input sampled at the latest rising edge
    logic curBit;   // input presented for the coming edge
  } sampleView_t;

endpackage

// File: rtl/seq110_datapath.sv
module seq110_datapath
  import seq110_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        aIn,
  output sampleView_t view
);

  logic lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastBit <= 1'b0;
    else       lastBit <= aIn;
  end

  assign view.lastBit = lastBit;
  assign view.curBit  = aIn;

endmodule

// File: rtl/seq110_control.sv
module seq110_control
  import seq110_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  sampleView_t view,
  output logic        yOut
);

  logic      patBit;
  logic      patNext;
  detState_t stateNow;

  // Set when a run of ones continues, or when a run of ones is broken by 0.
  always_comb begin
    patNext = (patBit & view.lastBit) | (view.lastBit & view.curBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) patBit <= 1'b0;
    else       patBit <= patNext;
  end

  assign stateNow = detState_t'({patBit, view.lastBit});
  assign yOut     = (stateNow == ST_HIT);

  // R2: run of ones followed by a 0 sample yields a detection.
  assert_detect_after_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateNow == ST_RUN && !view.curBit) |=> yOut);

  // R3: a detection needs a 1 as the previous sample.
  assert_hit_needs_one_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(yOut) |-> $past(view.lastBit));

  // R5: a longer run of ones is held until the 0 arrives.
  assert_run_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateNow == ST_RUN && view.curBit) |=> (stateNow == ST_RUN));

  // R6: a 1 sampled in the detection period starts the next match.
  assert_restart_after_hit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (yOut && view.curBit) |=> (stateNow == ST_ONE));

  // R7: never two detections in a row.
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    yOut |=> !yOut);

endmodule

// File: rtl/seq110_detector.sv
module seq110_detector
  import seq110_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic aIn,
  output logic yOut
);

  sampleView_t view;

  seq110_datapath u_datapath (
    .clk  (clk),
    .rstN (rstN),
    .aIn  (aIn),
    .view (view)
  );

  seq110_control u_control (
    .clk  (clk),
    .rstN (rstN),
    .view (view),
    .yOut (yOut)
  );

endmodule

// File: tb/test_seq110_detector.sv
`timescale 1ns/1ps
module test_seq110_detector;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aIn = 1'b0;
  logic yOut;

  int checks = 0;
  int fails = 0;
  logic [2:0] hist = 3'b000;
  logic expQ[$];
  string tagQ[$];
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  seq110_detector i_seq110_detector (
    .clk  (clk),
    .rstN (rstN),
    .aIn  (aIn),
    .yOut (yOut)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: yOut=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: present one bit for the next rising edge and predict yOut.
  task automatic drive(input logic b, input string req);
    @(negedge clk);
    aIn = b;
    hist = {hist[1:0], b};
    expQ.push_back(hist == 3'b110);
    tagQ.push_back(req);
  endtask

  task automatic driveSeq(input string bits, input string req);
    for (int i = 0; i < bits.len(); i++) drive(bits[i] == "1", req);
  endtask

  // Monitor: compare just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        string t;
        logic e;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, yOut, e);
      end
    end
  end

  task automatic doReset(input string req);
    wait (expQ.size() == 0);
    @(negedge clk);
    #1 rstN = 1'b0;
    #1 check(req, yOut, 1'b0);
    hist = 3'b000;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #3 check("R1", yOut, 1'b0);
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;

    driveSeq("110", "R2");
    driveSeq("010", "R3");
    driveSeq("100", "R3");
    driveSeq("011", "R3");
    driveSeq("0", "R3");
    driveSeq("111110", "R5");
    driveSeq("0110110", "R6");
    driveSeq("110100", "R7");

    // R4: change aIn inside the detection period; yOut must hold.
    driveSeq("0110", "R4");
    wait (expQ.size() == 0);
    @(negedge clk);
    aIn = 1'b1;
    #1 check("R4", yOut, 1'b1);
    #1 aIn = 1'b0;
    #1 check("R4", yOut, 1'b1);
    aIn = 1'b1;
    hist = {hist[1:0], 1'b1};
    expQ.push_back(1'b0);
    tagQ.push_back("R4");
    driveSeq("0", "R4");

    // R1: asynchronous reset while yOut is high.
    driveSeq("110", "R1");
    doReset("R1");
    driveSeq("00", "R1");

    // R8: history from before reset is dropped.
    driveSeq("11", "R8");
    doReset("R8");
    driveSeq("0", "R8");
    driveSeq("0110", "R8");

    wait (expQ.size() == 0);
    @(negedge clk);
    finished = 1;
    summary();
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      summary();
    end
  end

endmodule